// File: doc/BRIEF.md
# Handshaked Shift-Register Byte Transfer Controller

This block sits between a host processor and a small peripheral controller and carries whole packets of bytes across a single 8-bit shift register. The host steers every byte with three active-low lines held in a port-B register: it drives transfer-in-progress and transfer-acknowledge, and the block drives transfer-request back. A direction bit in an auxiliary control register says which way bytes flow. Any change of the acknowledge or in-progress levels advances the transfer by one byte. No shift clock is involved.

When the host sends, each advance copies the shift register into an outbound buffer. When in-progress is released, the collected bytes leave on a packet port as a one-cycle valid strobe with a length, and a random-access read port gives the bytes. When the host receives, a response packet written into the inbound buffer and committed with a length is presented one byte per advance in the shift register. The request line tells the host that a response is waiting and marks its last byte. Between transfers, the request line echoes the acknowledge level as a sync handshake. A single shift-register flag reports every completed step and is cleared by a shift-register read strobe.

Top module: `shift_handshake_link`

## Requirements
- R1: After reset, port B reads 0x38, the auxiliary register and the shift register read 0x00, the flag is low, pkt_valid is low, and both buffers are empty.
- R2: Port B bits are fixed: bit 3 is request, bit 4 is acknowledge and bit 5 is in-progress, all active low. The register select is 0 for port B, 1 for the auxiliary register and 2 for the shift register. Auxiliary bit 4 set means the host sends. Port B changes only on a port-B or auxiliary write, or on an inbound load.
- R3: While in-progress is low and the host sends, a port-B or auxiliary write that changes bit 4 or bit 5 against the current port B appends the shift register to the outbound buffer and sets the flag. Bytes past OUT_DEPTH are dropped.
- R4: While in-progress is low and the host receives, each such change loads the next unread inbound byte into the shift register and sets the flag. Loading the last byte forces request (bit 3) high. With no unread byte, nothing is loaded and the flag is untouched.
- R5: With in-progress high both before and after a write, a change of acknowledge copies the new acknowledge level into request and sets the flag.
- R6: A write that raises in-progress from low always sets the flag. If any outbound bytes were held, pkt_valid pulses for one cycle with pkt_len equal to the byte count, and the count returns to zero.
- R7: On an update with in-progress high that is not a sync step, and on an inbound load while in-progress is high, request is driven low if unread inbound bytes remain.
- R8: in_load sets the inbound size to in_len, resets the read position to zero and sets the flag.
- R9: sr_rd clears the flag, but a flag-setting event in the same cycle wins.
- R10: A write to the auxiliary register runs the same update as a port-B write, using the new direction bit and the current port B.
- R11: pkt_rdata shows the outbound byte at pkt_raddr, and byte 0 is the first byte captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Host register write strobe |
| reg_sel | input | 2 | Register select: 0 port B, 1 auxiliary, 2 shift register |
| reg_wdata | input | 8 | Host write data |
| sr_rd | input | 1 | Host shift-register read strobe, clears the flag |
| pb_q | output | 8 | Port B contents, including the request bit |
| acr_q | output | 8 | Auxiliary control register |
| sr_q | output | 8 | Shift register |
| sr_flag | output | 1 | Shift-register step flag |
| in_wr | input | 1 | Inbound buffer write strobe |
| in_waddr | input | 7 | Inbound buffer write address |
| in_wdata | input | 8 | Inbound buffer write data |
| in_load | input | 1 | Commit a response of in_len bytes |
| in_len | input | 8 | Response length, 0 to IN_DEPTH |
| pkt_valid | output | 1 | One-cycle strobe, packet handed off |
| pkt_len | output | 5 | Length of the last packet handed off |
| pkt_raddr | input | 4 | Outbound buffer read address |
| pkt_rdata | output | 8 | Outbound byte at pkt_raddr |

## Verification
The bench builds the block with its default parameters: a 16-byte outbound buffer and a 128-byte inbound buffer. With 16 bytes, the outbound limit is easy to reach, so an 18-byte host send checks that the packet stops at the limit and keeps its first and sixteenth bytes. Three-byte responses are enough to cover the first, middle and last reads, the request release on the last byte, and a further advance with nothing left. None of these depends on the inbound depth.

// File: rtl/shift_handshake_link.sv
module shift_handshake_link #(
  parameter int DW        = 8,
  parameter int OUT_DEPTH = 16,
  parameter int IN_DEPTH  = 128,
  parameter int REQ_BIT   = 3,
  parameter int ACK_BIT   = 4,
  parameter int TIP_BIT   = 5,
  parameter int DIR_BIT   = 4,
  parameter logic [DW-1:0] PB_RESET = 8'h38,
  localparam int OAW = $clog2(OUT_DEPTH),
  localparam int OCW = $clog2(OUT_DEPTH + 1),
  localparam int IAW = $clog2(IN_DEPTH),
  localparam int ICW = $clog2(IN_DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_wr,
  input  logic [1:0]     reg_sel,
  input  logic [DW-1:0]  reg_wdata,
  input  logic           sr_rd,
  output logic [DW-1:0]  pb_q,
  output logic [DW-1:0]  acr_q,
  output logic [DW-1:0]  sr_q,
  output logic           sr_flag,
  input  logic           in_wr,
  input  logic [IAW-1:0] in_waddr,
  input  logic [DW-1:0]  in_wdata,
  input  logic           in_load,
  input  logic [ICW-1:0] in_len,
  output logic           pkt_valid,
  output logic [OCW-1:0] pkt_len,
  input  logic [OAW-1:0] pkt_raddr,
  output logic [DW-1:0]  pkt_rdata
);
  localparam logic [1:0]     SEL_PB   = 2'd0;
  localparam logic [1:0]     SEL_ACR  = 2'd1;
  localparam logic [1:0]     SEL_SR   = 2'd2;
  localparam logic [OCW-1:0] OUT_FULL = OCW'(OUT_DEPTH);
  localparam logic [ICW-1:0] IN_FULL  = ICW'(IN_DEPTH);

  logic [DW-1:0]  out_buf [OUT_DEPTH];
  logic [DW-1:0]  in_buf  [IN_DEPTH];
  logic [OCW-1:0] out_cnt;
  logic [ICW-1:0] rd_idx, in_size;

  wire upd      = reg_wr && (reg_sel == SEL_PB || reg_sel == SEL_ACR);
  wire sr_wr    = reg_wr && reg_sel == SEL_SR;
  wire [DW-1:0] cand_b   = (reg_wr && reg_sel == SEL_PB)  ? reg_wdata : pb_q;
  wire [DW-1:0] cand_acr = (reg_wr && reg_sel == SEL_ACR) ? reg_wdata : acr_q;
  wire ack_chg  = cand_b[ACK_BIT] != pb_q[ACK_BIT];
  wire hs_chg   = ack_chg || (cand_b[TIP_BIT] != pb_q[TIP_BIT]);
  wire pending  = rd_idx < in_size;
  wire [ICW-1:0] rd_next = rd_idx + 1'b1;
  wire [ICW-1:0] len_cl  = (in_len > IN_FULL) ? IN_FULL : in_len;
  wire load_req = in_load && !upd && pb_q[TIP_BIT] && len_cl != '0;

  logic [DW-1:0] nxt_b;
  logic cap, feed, set_flag, emit;

  always_comb begin
    nxt_b = cand_b;
    cap = 1'b0;
    feed = 1'b0;
    set_flag = 1'b0;
    emit = 1'b0;
    if (upd) begin
      if (!cand_b[TIP_BIT]) begin
        if (cand_acr[DIR_BIT]) begin
          if (hs_chg && out_cnt < OUT_FULL) begin
            cap = 1'b1;
            set_flag = 1'b1;
          end
        end else if (hs_chg && pending) begin
          feed = 1'b1;
          set_flag = 1'b1;
          if (rd_next >= in_size) nxt_b[REQ_BIT] = 1'b1;
        end
      end else if (pb_q[TIP_BIT] && ack_chg) begin
        nxt_b[REQ_BIT] = cand_b[ACK_BIT];
        set_flag = 1'b1;
      end else begin
        if (!pb_q[TIP_BIT]) begin
          emit = out_cnt != '0;
          set_flag = 1'b1;
        end
        if (pending) nxt_b[REQ_BIT] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pb_q <= PB_RESET;
      acr_q <= '0;
      sr_q <= '0;
      sr_flag <= 1'b0;
      out_cnt <= '0;
      rd_idx <= '0;
      in_size <= '0;
      pkt_valid <= 1'b0;
      pkt_len <= '0;
    end else begin
      if (upd) begin
        pb_q <= nxt_b;
        acr_q <= cand_acr;
      end else if (load_req) begin
        pb_q[REQ_BIT] <= 1'b0;
      end
      if (sr_wr) sr_q <= reg_wdata;
      else if (feed) sr_q <= in_buf[rd_idx[IAW-1:0]];
      if (emit) out_cnt <= '0;
      else if (cap) out_cnt <= out_cnt + 1'b1;
      pkt_valid <= emit;
      if (emit) pkt_len <= out_cnt;
      if (in_load) begin
        rd_idx <= '0;
        in_size <= len_cl;
      end else if (feed) begin
        rd_idx <= rd_next;
      end
      if (set_flag || in_load) sr_flag <= 1'b1;
      else if (sr_rd) sr_flag <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (cap) out_buf[out_cnt[OAW-1:0]] <= sr_q;
    if (in_wr) in_buf[in_waddr] <= in_wdata;
  end

  assign pkt_rdata = out_buf[pkt_raddr];
endmodule

// File: rtl/shl_checks.sv
module shl_checks #(
  parameter int DW = 8,
  parameter int OUT_DEPTH = 16,
  parameter int OCW = 5,
  parameter int REQ_BIT = 3,
  parameter int ACK_BIT = 4,
  parameter int TIP_BIT = 5
) (
  input logic           clk,
  input logic           rst_n,
  input logic           reg_wr,
  input logic [1:0]     reg_sel,
  input logic [DW-1:0]  reg_wdata,
  input logic           sr_rd,
  input logic           in_load,
  input logic [DW-1:0]  pb_q,
  input logic           sr_flag,
  input logic           pkt_valid,
  input logic [OCW-1:0] pkt_len
);
  p_pkt_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid |-> (pkt_len != '0 && pkt_len <= OCW'(OUT_DEPTH)));

  p_end_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid |-> sr_flag);

  p_load_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_load |=> sr_flag);

  p_sync_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == 2'd0 && reg_wdata[TIP_BIT] && pb_q[TIP_BIT] &&
     reg_wdata[ACK_BIT] != pb_q[ACK_BIT])
    |=> (pb_q[REQ_BIT] == pb_q[ACK_BIT] && sr_flag));

  p_flag_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_rd && !reg_wr && !in_load) |=> !sr_flag);

  p_pb_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_wr && !in_load) |=> $stable(pb_q));
endmodule

bind shift_handshake_link shl_checks #(
  .DW(DW), .OUT_DEPTH(OUT_DEPTH), .OCW(OCW),
  .REQ_BIT(REQ_BIT), .ACK_BIT(ACK_BIT), .TIP_BIT(TIP_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
  .reg_wdata(reg_wdata), .sr_rd(sr_rd), .in_load(in_load), .pb_q(pb_q),
  .sr_flag(sr_flag), .pkt_valid(pkt_valid), .pkt_len(pkt_len)
);

// File: tb/tb_shift_handshake_link.sv
module tb_shift_handshake_link;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0, sr_rd = 1'b0, in_wr = 1'b0, in_load = 1'b0;
  logic [1:0] reg_sel = '0;
  logic [7:0] reg_wdata = '0, in_wdata = '0;
  logic [6:0] in_waddr = '0;
  logic [7:0] in_len = '0;
  logic [3:0] pkt_raddr = '0;
  logic [7:0] pb_q, acr_q, sr_q, pkt_rdata;
  logic [4:0] pkt_len;
  logic sr_flag, pkt_valid;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  shift_handshake_link dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .sr_rd(sr_rd), .pb_q(pb_q), .acr_q(acr_q),
    .sr_q(sr_q), .sr_flag(sr_flag), .in_wr(in_wr), .in_waddr(in_waddr),
    .in_wdata(in_wdata), .in_load(in_load), .in_len(in_len),
    .pkt_valid(pkt_valid), .pkt_len(pkt_len), .pkt_raddr(pkt_raddr),
    .pkt_rdata(pkt_rdata)
  );

  // op(2) data(8) exp_pb(8) exp_sr(8) exp_flag(1) exp_pkt(1); op 3 = inbound load
  localparam int NV = 16;
  localparam logic [27:0] VEC [NV] = '{
    {2'd1, 8'h10, 8'h38, 8'h00, 1'b0, 1'b0},
    {2'd2, 8'hA1, 8'h38, 8'hA1, 1'b0, 1'b0},
    {2'd0, 8'h18, 8'h18, 8'hA1, 1'b1, 1'b0},
    {2'd2, 8'hB2, 8'h18, 8'hB2, 1'b0, 1'b0},
    {2'd0, 8'h08, 8'h08, 8'hB2, 1'b1, 1'b0},
    {2'd0, 8'h38, 8'h38, 8'hB2, 1'b1, 1'b1},
    {2'd0, 8'h28, 8'h20, 8'hB2, 1'b1, 1'b0},
    {2'd0, 8'h38, 8'h38, 8'hB2, 1'b1, 1'b0},
    {2'd0, 8'h38, 8'h38, 8'hB2, 1'b0, 1'b0},
    {2'd3, 8'h03, 8'h30, 8'hB2, 1'b1, 1'b0},
    {2'd1, 8'h00, 8'h30, 8'hB2, 1'b0, 1'b0},
    {2'd0, 8'h10, 8'h10, 8'hC0, 1'b1, 1'b0},
    {2'd0, 8'h00, 8'h00, 8'hC1, 1'b1, 1'b0},
    {2'd0, 8'h10, 8'h18, 8'hC2, 1'b1, 1'b0},
    {2'd0, 8'h00, 8'h00, 8'hC2, 1'b0, 1'b0},
    {2'd0, 8'h38, 8'h38, 8'hC2, 1'b1, 1'b0}
  };

  function automatic string req_of(int i);
    case (i)
      0, 10: return "R10";
      1, 2, 3, 4: return "R3";
      5, 15: return "R6";
      6, 7, 8: return "R5";
      9: return "R7";
      default: return "R4";
    endcase
  endfunction

  task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic do_op(input logic [1:0] op, input logic [7:0] d, input logic rd);
    @(negedge clk);
    sr_rd = rd;
    if (op == 2'd3) begin
      in_load = 1'b1;
      in_len = d;
    end else begin
      reg_wr = 1'b1;
      reg_sel = op;
      reg_wdata = d;
    end
    @(negedge clk);
    reg_wr = 1'b0;
    in_load = 1'b0;
    sr_rd = 1'b0;
  endtask

  task automatic clr_flag();
    @(negedge clk);
    sr_rd = 1'b1;
    @(negedge clk);
    sr_rd = 1'b0;
  endtask

  task automatic fill(input int n, input logic [7:0] base);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_wr = 1'b1;
      in_waddr = 7'(k);
      in_wdata = base + 8'(k);
    end
    @(negedge clk);
    in_wr = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(pb_q, 8'h38, "R1 port B reset");
    chk(acr_q, 8'h00, "R1 aux reset");
    chk(sr_q, 8'h00, "R1 shift reset");
    chk({sr_flag, pkt_valid}, 2'b00, "R1 flag/strobe reset");

    fill(3, 8'hC0);
    chk(pb_q, 8'h38, "R2 inbound fill leaves port B");
    for (int i = 0; i < NV; i++) begin
      logic [27:0] v;
      v = VEC[i];
      do_op(v[27:26], v[25:18], 1'b0);
      chk(pb_q, v[17:10], $sformatf("%s vector %0d port B", req_of(i), i));
      chk(sr_q, v[9:2], $sformatf("%s vector %0d shift", req_of(i), i));
      chk(sr_flag, v[1], $sformatf("%s vector %0d flag", req_of(i), i));
      chk(pkt_valid, v[0], $sformatf("%s vector %0d strobe", req_of(i), i));
      if (i == 5) chk(pkt_len, 5'd2, "R6 packet length");
      if (i == 9) chk(sr_flag, 1'b1, "R8 load sets flag");
      clr_flag();
      chk(sr_flag, 1'b0, "R9 read clears flag");
    end
    pkt_raddr = 4'd0;
    #1 chk(pkt_rdata, 8'hA1, "R11 first packet byte");
    pkt_raddr = 4'd1;
    #1 chk(pkt_rdata, 8'hB2, "R11 second packet byte");

    // R3 overflow: 18 bytes sent, 16 kept
    do_op(2'd1, 8'h10, 1'b0);
    for (int k = 0; k < 18; k++) begin
      do_op(2'd2, 8'h40 + 8'(k), 1'b0);
      do_op(2'd0, (k % 2 == 0) ? 8'h18 : 8'h08, 1'b0);
    end
    do_op(2'd0, 8'h38, 1'b0);
    chk(pkt_valid, 1'b1, "R6 overflow packet strobe");
    chk(pkt_len, 5'd16, "R3 length capped at depth");
    @(negedge clk);
    chk(pkt_valid, 1'b0, "R6 strobe lasts one cycle");
    pkt_raddr = 4'd15;
    #1 chk(pkt_rdata, 8'h4F, "R3 last kept byte");
    pkt_raddr = 4'd0;
    #1 chk(pkt_rdata, 8'h40, "R11 byte 0 after overflow");

    // R9 set wins over a same-cycle read
    clr_flag();
    do_op(2'd0, 8'h28, 1'b1);
    chk(sr_flag, 1'b1, "R9 set beats clear");
    chk(pb_q, 8'h20, "R5 request follows acknowledge");
    do_op(2'd0, 8'h38, 1'b0);

    // R4 reload: index restarts at zero
    fill(2, 8'hD0);
    do_op(2'd1, 8'h00, 1'b0);
    do_op(2'd3, 8'h02, 1'b0);
    chk(pb_q, 8'h30, "R7 request low on load");
    do_op(2'd0, 8'h10, 1'b0);
    chk(sr_q, 8'hD0, "R8 read index restarts");
    chk(pb_q, 8'h10, "R4 first of two keeps request");
    do_op(2'd0, 8'h00, 1'b0);
    chk(sr_q, 8'hD1, "R4 second byte");
    chk(pb_q, 8'h08, "R4 last byte raises request");
    do_op(2'd0, 8'h38, 1'b0);
    chk(pkt_valid, 1'b0, "R6 no packet when empty");
    chk(sr_flag, 1'b1, "R6 end always flags");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired got hang expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule